// File: doc/BRIEF.md
# Capability Address CSR Write Legalizer

This block holds the three capability-extended control registers that carry an address: the exception return PC, the trap vector base and the default data capability. Each register stores a tag, a sealed flag, an infinite-bounds flag, opaque metadata and a reduced-width address. Software can write a register in two ways. A capability write carries the whole value. An address-only write is XLEN wide and replaces only the address.

Instead of running a full set-address representability check on every write, the block applies a few cheap rules:

- An address-only write keeps the tag only when the stored capability already spans the whole address space.
- Any address that the reduced storage cannot hold is converted and loses its tag.
- Alignment or trap-mode fixes that alter address bits clear the tag only when the effective capability is sealed.

In RV64 mode the address is kept in 40 flops (Sv39 sizing). Reads return it sign-extended to XLEN. In RV32 mode the conversion is bypassed.

Top module: `cap_csr_legalizer`

## Requirements
- R1: After reset every register reads with tag 0, sealed 0, infinite-bounds 0, metadata 0 and address 0.
- R2: A capability write (wr_full=1) replaces the tag, sealed flag, infinite-bounds flag, metadata and address together, subject to R5 to R10.
- R3: An address-only write (wr_full=0) leaves the sealed flag, infinite-bounds flag and metadata unchanged. The resulting tag is the previous tag when the stored infinite-bounds flag is 1, and 0 otherwise, before R5 and R10 apply.
- R4: In RV64 mode (rv32_mode=0) an address whose bits 63:38 all equal bit 38 is valid. It is stored unchanged and reads back unchanged.
- R5: In RV64 mode an invalid address is stored with bits 38:0 kept and bit 39 set to the inverse of bit 38. It reads back sign-extended from bit 39, and the written tag is cleared.
- R6: In RV32 mode (rv32_mode=1) bits 63:32 of the written address are ignored, the address reads back zero-extended, and no conversion clears the tag.
- R7: For the exception PC (wr_sel=0), bit 0 is forced to 0 when ialign16=1, and bits 1:0 are forced to 0 when ialign16=0.
- R8: For the trap vector (wr_sel=1), bits 1:0 are the mode: 0 is direct and 1 is vectored. Written values 0 and 1 are kept. Written values 2 and 3 leave the previous mode in place.
- R9: When the resulting trap vector mode is vectored, base bits 10:2 (RV64) or 6:2 (RV32) are forced to 0, so the whole table (512 or 32 entries) is aligned.
- R10: If R7, R8 or R9 changes any stored address bit relative to the converted address, the tag is cleared exactly when the effective sealed flag is 1. For a capability write that flag is the written one; for an address-only write it is the stored one.
- R11: The default data capability (wr_sel=2) gets no alignment and follows R2 to R6 only.
- R12: A write with wr_sel=3, or with wr_en=0, changes no register, and a write to one register leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 exception PC, 1 trap vector, 2 default data, 3 none |
| wr_full | input | 1 | 1 = capability write, 0 = address-only write |
| wr_tag | input | 1 | Written tag (capability write) |
| wr_sealed | input | 1 | Written sealed flag (capability write) |
| wr_inf | input | 1 | Written infinite-bounds flag (capability write) |
| wr_meta | input | META_W | Written metadata (capability write) |
| wr_addr | input | XLEN | Written address |
| rv32_mode | input | 1 | 1 = RV32 behaviour |
| ialign16 | input | 1 | 1 = 16-bit instruction alignment, 0 = 32-bit |
| rd_sel | input | 2 | Register to read; 3 reads zero |
| rd_tag | output | 1 | Read tag |
| rd_sealed | output | 1 | Read sealed flag |
| rd_inf | output | 1 | Read infinite-bounds flag |
| rd_meta | output | META_W | Read metadata |
| rd_addr | output | XLEN | Read address, extended to XLEN |

## Verification
The assertions check several invariants on every cycle:

- Exception PC bit 0 and trap vector mode bit 1 stay clear.
- Address-only writes never alter the metadata, and they drop the tag of a bounded capability.
- Invalid addresses never leave a tag behind.
- Unselected registers hold their value.

The exact converted and aligned address values, the choice between keeping and reverting the trap mode, and whether a sealed capability loses its tag when alignment changes a bit can only be shown by the bench's sweep. That sweep crosses every target, write form, seal and bounds state, alignment setting and XLEN mode with addresses placed at the valid/invalid boundary.

// File: rtl/cap_csr_pkg.sv
package cap_csr_pkg;
  localparam int unsigned NUM_CSR   = 3;
  localparam int unsigned KIND_EPC  = 0;
  localparam int unsigned KIND_TVEC = 1;
  localparam int unsigned KIND_DDC  = 2;
  localparam logic [1:0]  MODE_DIRECT = 2'd0;
  localparam logic [1:0]  MODE_VECTOR = 2'd1;
endpackage

// File: rtl/addr_conv.sv
module addr_conv #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 40
) (
  input  logic [XLEN-1:0]   wr_addr,
  input  logic              rv32,
  output logic [ADDR_W-1:0] st_addr,
  output logic              invalid
);
  localparam int unsigned CHK = ADDR_W - 2;

  logic [XLEN-1:CHK] hi_bits;
  assign hi_bits = wr_addr[XLEN-1:CHK];

  always_comb begin
    if (rv32) begin
      st_addr = ADDR_W'(wr_addr[31:0]);
      invalid = 1'b0;
    end else begin
      invalid = !((&hi_bits) || !(|hi_bits));
      st_addr = wr_addr[ADDR_W-1:0];
      if (invalid) st_addr[ADDR_W-1] = ~wr_addr[CHK];
    end
  end
endmodule

// File: rtl/csr_align.sv
module csr_align
  import cap_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned KIND       = 0,
  parameter int unsigned VEC_BITS64 = 11,
  parameter int unsigned VEC_BITS32 = 7
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        old_mode,
  input  logic              ialign16,
  input  logic              rv32,
  output logic [ADDR_W-1:0] out_addr
);
  generate
    if (KIND == KIND_EPC) begin : g_epc
      logic unused_epc;
      assign unused_epc = ^{old_mode, rv32};
      always_comb begin
        out_addr    = in_addr;
        out_addr[0] = 1'b0;
        if (!ialign16) out_addr[1] = 1'b0;
      end
    end else if (KIND == KIND_TVEC) begin : g_tvec
      logic [1:0] mode;
      logic       unused_tvec;
      assign unused_tvec = ialign16;
      always_comb begin
        mode = in_addr[1:0];
        if (mode[1]) mode = old_mode;
        out_addr = {in_addr[ADDR_W-1:2], mode};
        if (mode == MODE_VECTOR) begin
          for (int i = 2; i < int'(VEC_BITS64); i++) begin
            if (!rv32 || (i < int'(VEC_BITS32))) out_addr[i] = 1'b0;
          end
        end
      end
    end else begin : g_plain
      logic unused_plain;
      assign unused_plain = ^{old_mode, ialign16, rv32};
      assign out_addr = in_addr;
    end
  endgenerate
endmodule

// File: rtl/csr_slot.sv
module csr_slot
  import cap_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned META_W     = 8,
  parameter int unsigned KIND       = 0,
  parameter int unsigned VEC_BITS64 = 11,
  parameter int unsigned VEC_BITS32 = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_hit,
  input  logic              wr_full,
  input  logic              wr_tag,
  input  logic              wr_sealed,
  input  logic              wr_inf,
  input  logic [META_W-1:0] wr_meta,
  input  logic [ADDR_W-1:0] conv_addr,
  input  logic              conv_invalid,
  input  logic              ialign16,
  input  logic              rv32,
  output logic              tag_q,
  output logic              sealed_q,
  output logic              inf_q,
  output logic [META_W-1:0] meta_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic              tag_d, sealed_d, inf_d;
  logic [META_W-1:0] meta_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] aligned;
  logic              base_tag, seal_eff, bits_changed;

  csr_align #(
    .ADDR_W(ADDR_W), .KIND(KIND),
    .VEC_BITS64(VEC_BITS64), .VEC_BITS32(VEC_BITS32)
  ) u_align (
    .in_addr (conv_addr),
    .old_mode(addr_q[1:0]),
    .ialign16(ialign16),
    .rv32    (rv32),
    .out_addr(aligned)
  );

  always_comb begin
    if (wr_full) begin
      base_tag = wr_tag;
      seal_eff = wr_sealed;
      sealed_d = wr_sealed;
      inf_d    = wr_inf;
      meta_d   = wr_meta;
    end else begin
      base_tag = tag_q & inf_q;
      seal_eff = sealed_q;
      sealed_d = sealed_q;
      inf_d    = inf_q;
      meta_d   = meta_q;
    end
    bits_changed = (aligned != conv_addr);
    tag_d  = base_tag & ~conv_invalid & ~(bits_changed & seal_eff);
    addr_d = aligned;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q    <= 1'b0;
      sealed_q <= 1'b0;
      inf_q    <= 1'b0;
      meta_q   <= '0;
      addr_q   <= '0;
    end else if (wr_hit) begin
      tag_q    <= tag_d;
      sealed_q <= sealed_d;
      inf_q    <= inf_d;
      meta_q   <= meta_d;
      addr_q   <= addr_d;
    end
  end

  // R3
  narrow_meta_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_hit && !wr_full) |=> (meta_q == $past(meta_q) && sealed_q == $past(sealed_q)
                              && inf_q == $past(inf_q)));

  // R3
  narrow_bounded_tag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_hit && !wr_full && !inf_q) |=> !tag_q);

  // R5
  invalid_untag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_hit && conv_invalid) |=> !tag_q);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_hit |=> ($stable(addr_q) && $stable(tag_q) && $stable(meta_q)));

  generate
    if (KIND == KIND_EPC) begin : g_epc_chk
      // R7
      epc_low_bit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        addr_q[0] == 1'b0);
    end else if (KIND == KIND_TVEC) begin : g_tvec_chk
      // R8
      tvec_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        addr_q[1] == 1'b0);
    end
  endgenerate
endmodule

// File: rtl/cap_csr_legalizer.sv
module cap_csr_legalizer
  import cap_csr_pkg::*;
#(
  parameter int unsigned XLEN        = 64,
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned META_W      = 8,
  parameter int unsigned MAX_CAUSE64 = 511,
  parameter int unsigned MAX_CAUSE32 = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_full,
  input  logic              wr_tag,
  input  logic              wr_sealed,
  input  logic              wr_inf,
  input  logic [META_W-1:0] wr_meta,
  input  logic [XLEN-1:0]   wr_addr,
  input  logic              rv32_mode,
  input  logic              ialign16,
  input  logic [1:0]        rd_sel,
  output logic              rd_tag,
  output logic              rd_sealed,
  output logic              rd_inf,
  output logic [META_W-1:0] rd_meta,
  output logic [XLEN-1:0]   rd_addr
);
  localparam int unsigned VEC_BITS64 = $clog2(MAX_CAUSE64 + 1) + 2;
  localparam int unsigned VEC_BITS32 = $clog2(MAX_CAUSE32 + 1) + 2;
  localparam int unsigned EXT_W      = XLEN - ADDR_W;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [ADDR_W-1:0] conv_addr;
  logic              conv_invalid;

  addr_conv #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_conv (
    .wr_addr(wr_addr),
    .rv32   (rv32_mode),
    .st_addr(conv_addr),
    .invalid(conv_invalid)
  );

  logic              s_tag    [NUM_CSR];
  logic              s_sealed [NUM_CSR];
  logic              s_inf    [NUM_CSR];
  logic [META_W-1:0] s_meta   [NUM_CSR];
  logic [ADDR_W-1:0] s_addr   [NUM_CSR];

  for (genvar k = 0; k < NUM_CSR; k++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_sel == 2'(k));
    csr_slot #(
      .ADDR_W(ADDR_W), .META_W(META_W), .KIND(k),
      .VEC_BITS64(VEC_BITS64), .VEC_BITS32(VEC_BITS32)
    ) u_slot (
      .clk(clk), .rst_ni(rst_ni), .wr_hit(hit), .wr_full(wr_full),
      .wr_tag(wr_tag), .wr_sealed(wr_sealed), .wr_inf(wr_inf), .wr_meta(wr_meta),
      .conv_addr(conv_addr), .conv_invalid(conv_invalid),
      .ialign16(ialign16), .rv32(rv32_mode),
      .tag_q(s_tag[k]), .sealed_q(s_sealed[k]), .inf_q(s_inf[k]),
      .meta_q(s_meta[k]), .addr_q(s_addr[k])
    );
  end

  always_comb begin
    rd_tag    = 1'b0;
    rd_sealed = 1'b0;
    rd_inf    = 1'b0;
    rd_meta   = '0;
    rd_addr   = '0;
    for (int k = 0; k < int'(NUM_CSR); k++) begin
      if (rd_sel == 2'(k)) begin
        rd_tag    = s_tag[k];
        rd_sealed = s_sealed[k];
        rd_inf    = s_inf[k];
        rd_meta   = s_meta[k];
        rd_addr   = {{EXT_W{s_addr[k][ADDR_W-1]}}, s_addr[k]};
      end
    end
  end
endmodule

// File: tb/cap_csr_legalizer_tb.sv
module cap_csr_legalizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int META_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, wr_full, wr_tag, wr_sealed, wr_inf, rv32_mode, ialign16;
  logic [1:0]        wr_sel, rd_sel;
  logic [META_W-1:0] wr_meta, rd_meta;
  logic [63:0]       wr_addr, rd_addr;
  logic              rd_tag, rd_sealed, rd_inf;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic              m_tag    [3];
  logic              m_sealed [3];
  logic              m_inf    [3];
  logic [META_W-1:0] m_meta   [3];
  logic [63:0]       m_addr   [3];
  string             lbl_tag, lbl_addr, lbl_meta;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_csr_legalizer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_full(wr_full),
    .wr_tag(wr_tag), .wr_sealed(wr_sealed), .wr_inf(wr_inf), .wr_meta(wr_meta),
    .wr_addr(wr_addr), .rv32_mode(rv32_mode), .ialign16(ialign16), .rd_sel(rd_sel),
    .rd_tag(rd_tag), .rd_sealed(rd_sealed), .rd_inf(rd_inf), .rd_meta(rd_meta),
    .rd_addr(rd_addr)
  );

  function automatic logic [63:0] pick_addr(int i);
    case (i)
      0: return 64'h0000_0000_0000_1235;
      1: return 64'hFFFF_FFC0_0000_0102;
      2: return 64'h0000_0040_0000_0000;
      3: return 64'h8000_0000_0000_0007;
      4: return 64'h0000_003F_FFFF_FFFC;
      5: return 64'hFFFF_FFBF_FFFF_FFFD;
      6: return 64'h1234_5678_9ABC_DEF1;
      default: return 64'h0000_0000_8000_07FC;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic check_slot(int s, string rt, string ra, string rm);
    rd_sel = 2'(s);
    #1;
    check(rt, {63'd0, rd_tag}, {63'd0, m_tag[s]});
    check(ra, rd_addr, m_addr[s]);
    check(rm, {54'd0, rd_sealed, rd_inf, rd_meta}, {54'd0, m_sealed[s], m_inf[s], m_meta[s]});
  endtask

  // Model of one write, from the requirements.
  task automatic model_write(int sel, bit full, bit t, bit sl, bit inf,
                             logic [META_W-1:0] meta, logic [63:0] a, bit r32, bit ia16);
    logic [63:0] st, pre;
    logic [39:0] bad40;
    bit inv, chg, seff, btag;
    logic [1:0] md;
    lbl_meta = full ? "R2" : "R3";
    if (sel == 3) begin
      lbl_tag = "R12"; lbl_addr = "R12"; lbl_meta = "R12";
      return;
    end
    if (r32) begin
      inv = 0;
      st = {32'd0, a[31:0]};
    end else begin
      inv = ($signed(a) < -64'sd274877906944) || ($signed(a) > 64'sd274877906943);
      if (!inv) st = a;
      else begin
        bad40 = {~a[38], a[38:0]};
        st = {{24{bad40[39]}}, bad40};
      end
    end
    pre = st;
    if (sel == 0) st = st & ~(ia16 ? 64'd1 : 64'd3);
    else if (sel == 1) begin
      md = a[1:0];
      if (md > 2'd1) md = m_addr[1][1:0];
      st = (st & ~64'd3) | 64'(md);
      if (md == 2'd1) st = st & ~(r32 ? 64'd124 : 64'd2044);
    end
    chg  = (st != pre);
    seff = full ? sl : m_sealed[sel];
    btag = full ? t : (m_tag[sel] & m_inf[sel]);
    if (r32) lbl_addr = "R6";
    else if (inv) lbl_addr = "R5";
    else if (sel == 0) lbl_addr = "R7";
    else if (sel == 1) lbl_addr = (md == 2'd1) ? "R9" : "R8";
    else lbl_addr = "R4";
    if (chg && seff) lbl_tag = "R10";
    else if (inv) lbl_tag = "R5";
    else if (sel == 2) lbl_tag = "R11";
    else lbl_tag = full ? "R2" : "R3";
    m_tag[sel]  = btag & ~inv & ~(chg & seff);
    m_addr[sel] = st;
    if (full) begin
      m_sealed[sel] = sl;
      m_inf[sel]    = inf;
      m_meta[sel]   = meta;
    end
  endtask

  task automatic do_write(int sel, bit full, bit t, bit sl, bit inf,
                          logic [META_W-1:0] meta, logic [63:0] a, bit r32, bit ia16);
    wr_en = 1; wr_sel = 2'(sel); wr_full = full; wr_tag = t; wr_sealed = sl;
    wr_inf = inf; wr_meta = meta; wr_addr = a; rv32_mode = r32; ialign16 = ia16;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    model_write(sel, full, t, sl, inf, meta, a, r32, ia16);
    for (int s = 0; s < 3; s++) begin
      if (s == sel) check_slot(s, lbl_tag, lbl_addr, lbl_meta);
      else check_slot(s, "R12", "R12", "R12");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_full = 0; wr_tag = 0; wr_sealed = 0;
    wr_inf = 0; wr_meta = 0; wr_addr = 0; rv32_mode = 0; ialign16 = 0; rd_sel = 0;
    for (int s = 0; s < 3; s++) begin
      m_tag[s] = 0; m_sealed[s] = 0; m_inf[s] = 0; m_meta[s] = 0; m_addr[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state of every register
    for (int s = 0; s < 3; s++) check_slot(s, "R1", "R1", "R1");

    // R12: strobe low leaves everything alone
    wr_sel = 0; wr_full = 1; wr_tag = 1; wr_addr = 64'h44; wr_meta = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 3; s++) check_slot(s, "R12", "R12", "R12");

    for (int r = 0; r < 2; r++)
      for (int sel = 0; sel < 4; sel++)
        for (int f = 0; f < 2; f++)
          for (int sl = 0; sl < 2; sl++)
            for (int inf = 0; inf < 2; inf++)
              for (int ia = 0; ia < 2; ia++)
                for (int ai = 0; ai < 8; ai++) begin
                  do_write(sel, 1, 1, sl[0], inf[0], 8'(8'h30 + ai),
                           64'h0000_0000_0000_0801, r[0], ia[0]);
                  do_write(sel, f[0], 1, ~sl[0], ~inf[0], 8'(8'hC0 + ai),
                           pick_addr(ai), r[0], ia[0]);
                end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule